// File: doc/BRIEF.md
# Protected Control Register Write Sequencer

This block protects a one-byte nonvolatile configuration register behind a three-step unlock. It sits behind a serial bus front end that has already found the bit boundaries and matched the slave address. The block therefore sees each transaction as three kinds of event: a start pulse, one pulse per received data byte, and a stop pulse. It keeps two volatile latches, write-enable and register-write-enable. It decides whether each byte is acknowledged, and it applies the effect of a transaction only when that transaction's stop arrives.

Software first sends 0x02, which sets write-enable. It then sends 0x06, which sets both latches. The third byte carries the new settings. That byte has the layout `q x y s t 0 1 r`, from bit 7 down to bit 0:

- q and r are the power-on delay select bits.
- x and y are the two monitor status bits.
- s and t are the two block-lock bits.

A commit writes the six free bits and clears register-write-enable. It then holds `busy` high for a parameterised number of cycles, which models the nonvolatile write time. If bit 2 of the third byte is set, the byte only re-arms register-write-enable. A write-protect input suppresses commits. Single-byte reads return the stored register at any time, including while busy.

Top module: `prot_cfg_seq`

## Requirements
- R1: After reset, `wel` and `rwel` are 0, `cfg_q` is 0x02, and `busy`, `ack_valid` and `rd_valid` are 0.
- R2: A one-byte write of 0x02 with `rwel` clear is acknowledged, and at its stop it sets `wel`.
- R3: A one-byte write of 0x06 with `rwel` clear is acknowledged, and at its stop it sets both `wel` and `rwel`. `rwel` is never 1 while `wel` is 0.
- R4: With both latches set, a byte with bit 1 = 1 and bit 2 = 0 is acknowledged. At stop (with `wp` low) it stores bits 7..3 and bit 0 into `cfg_q`, with bits 2..1 reading 01, clears `rwel` and keeps `wel`. The sequence 0x02, 0x06, 0x02 therefore leaves `cfg_q` = 0x02.
- R5: With both latches set, a byte with bits 2..1 = 11 is acknowledged and leaves `cfg_q` unchanged, with both latches still set.
- R6: After a commit stop, `busy` is high for exactly COMMIT_CYCLES cycles. A data byte received while busy is not acknowledged, and its transaction has no effect.
- R7: A second data byte in one transaction is not acknowledged, and the whole transaction has no effect.
- R8: If `wp` is high at the stop of a commit, `cfg_q`, `wel` and `rwel` stay unchanged and `busy` stays low.
- R9: Any other byte is not acknowledged, and at stop it clears both latches.
- R10: A `rd_req` pulse gives `rd_valid` one cycle later, with `rd_data` equal to `cfg_q`. Reads never change the latches.
- R11: Nothing changes before the stop: the latches and `cfg_q` hold their values between the data byte and the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start-of-write-transaction pulse |
| txn_stop | input | 1 | Stop-of-transaction pulse |
| wr_valid | input | 1 | Data byte received pulse |
| wr_data | input | 8 | Received data byte |
| rd_req | input | 1 | Single-byte register read request |
| wp | input | 1 | Write-protect, sampled at stop |
| ack_valid | output | 1 | Acknowledge decision valid (one cycle after `wr_valid`) |
| ack | output | 1 | 1 = byte acknowledged |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Commit in progress |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| cfg_q | output | 8 | Stored register value |

## Verification
The hardest state to reach is a write arriving while a commit is still in progress. A full unlock and commit must complete first, and then a new transaction must land inside the busy window. The bench closes a commit without waiting for it to finish and sends a byte straight away. It then checks the missing acknowledge and the unchanged state after `busy` falls. A random stream of unlock codes, plausible commit bytes, arbitrary bytes, two-byte frames and write-protect settings drives the latches through every pairing of states.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CODE_SET_WEL  = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_SET_BOTH = 8'h06;
  localparam logic [BYTE_W-1:0] NV_KEEP_MASK  = 8'hF9;
  localparam logic [BYTE_W-1:0] NV_FIXED      = 8'h02;

  typedef enum logic [2:0] {
    OP_BAD,
    OP_SET_WEL,
    OP_SET_BOTH,
    OP_KEEP_RWEL,
    OP_COMMIT
  } pcs_op_e;
endpackage

// File: rtl/pcs_classify.sv
module pcs_classify
  import pcs_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  input  logic              wel,
  input  logic              rwel,
  output pcs_op_e           op
);
  always_comb begin
    op = OP_BAD;
    if (rwel && wel) begin
      if (data[1]) op = data[2] ? OP_KEEP_RWEL : OP_COMMIT;
    end else if (data == CODE_SET_WEL) begin
      op = OP_SET_WEL;
    end else if (data == CODE_SET_BOTH) begin
      op = OP_SET_BOTH;
    end
  end
endmodule

// File: rtl/pcs_frame_tracker.sv
module pcs_frame_tracker
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    stop,
  input  logic    byte_valid,
  input  pcs_op_e op_in,
  input  logic    busy,
  output logic    ack_valid,
  output logic    ack,
  output logic    apply_fire,
  output pcs_op_e apply_op
);
  logic       open_q;
  logic [1:0] cnt_q;
  logic       abort_q;
  pcs_op_e    op_q;
  logic       take;

  assign take       = open_q && byte_valid && (cnt_q == 2'd0) && !busy;
  assign apply_fire = stop && open_q && !abort_q && (cnt_q == 2'd1);
  assign apply_op   = op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      cnt_q     <= 2'd0;
      abort_q   <= 1'b0;
      op_q      <= OP_BAD;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= byte_valid;
      ack       <= take && (op_in != OP_BAD);
      if (start) begin
        open_q  <= 1'b1;
        cnt_q   <= 2'd0;
        abort_q <= 1'b0;
      end else if (stop) begin
        open_q <= 1'b0;
      end else if (open_q && byte_valid) begin
        if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
        if (take) op_q <= op_in;
        else      abort_q <= 1'b1;
      end
    end
  end

  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && byte_valid) |=> (ack_valid && !ack));
  assert_second_nack_R7: assert property (@(posedge clk) disable iff (rst)
    (open_q && byte_valid && cnt_q != 2'd0) |=> !ack);
endmodule

// File: rtl/pcs_commit_timer.sv
module pcs_commit_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      cnt_q <= CW'(CYCLES);
      busy  <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      busy  <= (cnt_q != CW'(1));
    end
  end

  assert_load_busy_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/prot_cfg_seq.sv
module prot_cfg_seq
  import pcs_pkg::*;
#(
  parameter int COMMIT_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              txn_stop,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              wp,
  output logic              ack_valid,
  output logic              ack,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              wel,
  output logic              rwel,
  output logic [BYTE_W-1:0] cfg_q
);
  pcs_op_e byte_op;
  pcs_op_e apply_op;
  logic    apply_fire;
  logic    commit_fire;

  pcs_classify u_classify (
    .data (wr_data),
    .wel  (wel),
    .rwel (rwel),
    .op   (byte_op)
  );

  pcs_frame_tracker u_frame (
    .clk        (clk),
    .rst        (rst),
    .start      (txn_start),
    .stop       (txn_stop),
    .byte_valid (wr_valid),
    .op_in      (byte_op),
    .busy       (busy),
    .ack_valid  (ack_valid),
    .ack        (ack),
    .apply_fire (apply_fire),
    .apply_op   (apply_op)
  );

  assign commit_fire = apply_fire && (apply_op == OP_COMMIT) && !wp;

  pcs_commit_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (commit_fire),
    .busy (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel   <= 1'b0;
      rwel  <= 1'b0;
      cfg_q <= NV_FIXED;
    end else if (apply_fire) begin
      case (apply_op)
        OP_SET_WEL:   wel <= 1'b1;
        OP_SET_BOTH:  begin wel <= 1'b1; rwel <= 1'b1; end
        OP_KEEP_RWEL: rwel <= 1'b1;
        OP_COMMIT: if (!wp) begin
          cfg_q <= (wr_hold & NV_KEEP_MASK) | NV_FIXED;
          rwel  <= 1'b0;
        end
        default:      begin wel <= 1'b0; rwel <= 1'b0; end
      endcase
    end
  end

  // Byte captured alongside the op so the commit stores the accepted value.
  logic [BYTE_W-1:0] wr_hold;
  always_ff @(posedge clk) begin
    if (rst) wr_hold <= '0;
    else if (wr_valid && !busy && byte_op == OP_COMMIT && !apply_fire) wr_hold <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= cfg_q;
    end
  end

  assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
    rwel |-> wel);
  assert_commit_clears_rwel_R4: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> (!rwel && busy));
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(cfg_q));
  assert_read_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (apply_fire && wp && !busy) |=> !busy);
endmodule

// File: tb/prot_cfg_seq_bench.sv
module prot_cfg_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_start = 0, txn_stop = 0, wr_valid = 0, rd_req = 0, wp = 0;
  logic [7:0] wr_data = '0;
  logic ack_valid, ack, rd_valid, busy, wel, rwel;
  logic [7:0] rd_data, cfg_q;

  int checks = 0;
  int errors = 0;
  logic m_wel = 0, m_rwel = 0;
  logic [7:0] m_cfg = 8'h02;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_cfg_seq #(.COMMIT_CYCLES(CYC)) u_prot_cfg_seq (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .wp(wp),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .wel(wel), .rwel(rwel), .cfg_q(cfg_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 bad, 1 set wel, 2 set both, 3 keep rwel, 4 commit
  function automatic int model_op(input logic [7:0] b, input logic w, input logic r);
    if (w && r) return b[1] ? (b[2] ? 3 : 4) : 0;
    if (b == 8'h02) return 1;
    if (b == 8'h06) return 2;
    return 0;
  endfunction

  task automatic check_state(input string req);
    chk(wel == m_wel, {req, " wel"}, wel, m_wel);
    chk(rwel == m_rwel, {req, " rwel"}, rwel, m_rwel);
    chk(cfg_q == m_cfg, {req, " cfg"}, cfg_q, m_cfg);
  endtask

  task automatic wait_idle(input bool_expect_commit);
    int n = 0;
    while (busy && n < CYC + 8) begin n++; @(negedge clk); end
    if (bool_expect_commit) chk(n == CYC, "R6 busy length", n, CYC);
  endtask

  task automatic wr_txn(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                        input logic w, input bit wait_busy, input bit in_busy);
    int op;
    bit commit;
    op = model_op(b0, m_wel, m_rwel);
    @(negedge clk); txn_start = 1;
    @(negedge clk); txn_start = 0; wr_valid = 1; wr_data = b0;
    @(negedge clk); wr_valid = 0;
    chk(ack_valid == 1, "R2 ack_valid", ack_valid, 1);
    chk(ack == (!in_busy && op != 0), in_busy ? "R6 busy nack" : "R9 ack decision",
        ack, (!in_busy && op != 0));
    check_state("R11 before stop");
    if (nb == 2) begin
      wr_valid = 1; wr_data = b1;
      @(negedge clk); wr_valid = 0;
      chk(ack == 0, "R7 second byte nack", ack, 0);
    end
    txn_stop = 1; wp = w;
    @(negedge clk); txn_stop = 0; wp = 0;
    commit = 0;
    if (nb == 1 && !in_busy) begin
      case (op)
        1: m_wel = 1;
        2: begin m_wel = 1; m_rwel = 1; end
        3: m_rwel = 1;
        4: if (!w) begin m_cfg = (b0 & 8'hF9) | 8'h02; m_rwel = 0; commit = 1; end
        default: begin m_wel = 0; m_rwel = 0; end
      endcase
    end
    check_state(op == 4 ? (w ? "R8 wp" : "R4 commit") : (nb == 2 ? "R7 abort" : "R5 R3 R2 R9 stop"));
    if (!in_busy) chk(busy == commit, commit ? "R6 busy rise" : "R8 no busy", busy, commit);
    if (wait_busy) wait_idle(commit);
  endtask

  task automatic rd_chk();
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(rd_valid == 1, "R10 rd_valid", rd_valid, 1);
    chk(rd_data == m_cfg, "R10 rd_data", rd_data, m_cfg);
    check_state("R10 no side effect");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(wel == 0 && rwel == 0, "R1 latches", {wel, rwel}, 0);
    chk(cfg_q == 8'h02, "R1 cfg", cfg_q, 8'h02);
    chk(busy == 0 && ack_valid == 0 && rd_valid == 0, "R1 outputs", {busy, ack_valid, rd_valid}, 0);

    // R2 R3 R4 full unlock and commit
    wr_txn(1, 8'h02, 0, 0, 1, 0);
    wr_txn(1, 8'h06, 0, 0, 1, 0);
    wr_txn(1, 8'hFB, 0, 0, 1, 0);
    rd_chk();
    // R5 re-arm escape
    wr_txn(1, 8'h06, 0, 0, 1, 0);
    wr_txn(1, 8'h0E, 0, 0, 1, 0);
    // R4 02,06,02 clears
    wr_txn(1, 8'h02, 0, 0, 1, 0);
    rd_chk();
    // R8 write protect
    wr_txn(1, 8'h06, 0, 0, 1, 0);
    wr_txn(1, 8'hFB, 0, 1, 1, 0);
    // R7 two bytes
    wr_txn(2, 8'hFB, 8'h02, 0, 1, 0);
    // R6 write while busy
    wr_txn(1, 8'h83, 0, 0, 0, 0);
    wr_txn(1, 8'h06, 0, 0, 0, 1);
    wait_idle(0);
    check_state("R6 after busy write");
    // R9 bad byte clears
    wr_txn(1, 8'h06, 0, 0, 1, 0);
    wr_txn(1, 8'h00, 0, 0, 1, 0);

    for (int i = 0; i < 300; i++) begin
      int sel;
      logic [7:0] b;
      sel = $urandom % 4;
      case (sel)
        0: b = 8'h02;
        1: b = 8'h06;
        2: b = 8'($urandom) | 8'h02;
        default: b = 8'($urandom);
      endcase
      wr_txn(($urandom % 8 == 0) ? 2 : 1, b, 8'($urandom), ($urandom % 5 == 0), 1, 0);
      if ($urandom % 4 == 0) rd_chk();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule